// File: doc/BRIEF.md
# Hardware Semaphore Bank with Per-Processor Free Interrupts

This block holds a bank of sixteen semaphores shared by up to three processors. Each processor has its own request port: a request, a write strobe, a five-bit word address and a 32-bit write word. One registered 32-bit response word comes back on the cycle after each request. A processor takes a semaphore in a single bus read. The response tells it whether the semaphore is locked, whether the attempt was refused, and which processor now holds it. The holder gives the semaphore back by writing its own two-bit lock ID to that semaphore's address. The block refuses any release that does not carry the holder's ID.

Every processor also has a private interrupt bank: an enable mask, a raw free-event status, a masked status and a write-one-to-clear register. When a semaphore is released, the raw bit for that semaphore is set in each bank that has it enabled. A processor that lost a race can then sleep until its interrupt line rises. Processor index p (0, 1 or 2) owns lock ID p+1. ID 0 means free. When several ports make requests in the same cycle, the requests take effect one after another in ascending port order.

Top module: `hsem_top`

## Requirements
- R1: After reset every semaphore is free, every enable, raw and masked status bit is zero, every interrupt line is low and every response word is zero.
- R2: A read of semaphore address s (0x00–0x0F) while it is free locks it to the reader. The response is bit 31 = 1, bit 30 = 0 and bits [1:0] = the reader's ID, with all other bits zero.
- R3: A read of a semaphore held by another ID leaves the owner unchanged. The response is bit 31 = 1, bit 30 = 1 and bits [1:0] = the holder's ID.
- R4: A write to a held semaphore whose word equals the holder's ID frees it. The response is all zero, and a later read from any port acquires the semaphore.
- R5: A release is refused when the semaphore is free, the ID differs from the holder's, the ID is 0, or any bit above [1:0] is set. The response then has bit 30 = 1, bit 31 = locked state and bits [1:0] = current owner, and the state is unchanged.
- R6: Requests from several ports in one cycle take effect in ascending port order. On a simultaneous read of a free semaphore the lowest port wins, and the others receive the R3 word naming the winner. A release by a lower port lets a higher port's read in the same cycle acquire the semaphore.
- R7: Offset 0x10 is the port's own enable mask, one bit per semaphore. It can be written and read back, and bits 31:16 are ignored and read as zero.
- R8: A successful release of semaphore s sets raw bit s (offset 0x11) in every bank whose enable bit s was set, and in no other bank.
- R9: Offset 0x12 reads raw status AND enable for the port's bank.
- R10: Writing ones to offset 0x13 clears those raw bits in the port's bank. The offset reads as zero. A release event in the same cycle wins over the clear.
- R11: Interrupt line p is high exactly when bank p's masked status is nonzero.
- R12: Writes to offsets 0x11, 0x12 and 0x14–0x1F have no effect, and reads of 0x14–0x1F return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_req | input | NPROC | Request strobe, one per port |
| p_we | input | NPROC | Write when 1, read when 0 |
| p_addr | input | NPROC*5 | Word address per port, port 0 in the low bits |
| p_wdata | input | NPROC*32 | Write word per port |
| p_rdata | output | NPROC*32 | Registered response word per port |
| irq | output | NPROC | Free-event interrupt per processor |

## Verification
The assertions run on every cycle. They check three things: no owner passes directly to another owner unless a release happened in that cycle, an owner only ever appears through a read, and every semaphore read answers with the locked flag. They also check that raw bits appear only on enabled release events and vanish after a clear that had no competing release. The bench's scenarios are the only evidence for the exact response words, the refusal cases, the port-order resolution of same-cycle contention, and the per-bank enable, masked status and interrupt values across all sixteen semaphores.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
    localparam int RSP_LOCKED_BIT = 31;
    localparam int RSP_DENIED_BIT = 30;

    typedef enum logic [1:0] {
        IRQ_ENABLE = 2'd0,
        IRQ_RAW    = 2'd1,
        IRQ_MASKED = 2'd2,
        IRQ_CLEAR  = 2'd3
    } irq_reg_e;
endpackage

// File: rtl/hsem_lock_core.sv
module hsem_lock_core #(
    parameter int NSEM  = 16,
    parameter int NPROC = 3,
    parameter int IDW   = 2,
    parameter int SIW   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPROC-1:0]            rd_req,
    input  logic [NPROC-1:0]            wr_req,
    input  logic [NPROC-1:0][SIW-1:0]   sem_idx,
    input  logic [NPROC-1:0][IDW-1:0]   rel_id,
    output logic [NPROC-1:0][IDW-1:0]   rsp_owner,
    output logic [NPROC-1:0]            rsp_deny,
    output logic [NSEM-1:0]             rel_mask
);
    typedef struct packed {
        logic [NSEM-1:0][IDW-1:0] owner;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        rsp_owner = '0;
        rsp_deny  = '0;
        rel_mask  = '0;
        for (int p = 0; p < NPROC; p++) begin
            if (rd_req[p]) begin
                if (st_d.owner[sem_idx[p]] == '0) begin
                    st_d.owner[sem_idx[p]] = IDW'(p + 1);
                end
                rsp_owner[p] = st_d.owner[sem_idx[p]];
                rsp_deny[p]  = st_d.owner[sem_idx[p]] != IDW'(p + 1);
            end else if (wr_req[p]) begin
                if (st_d.owner[sem_idx[p]] != '0 &&
                    st_d.owner[sem_idx[p]] == rel_id[p]) begin
                    st_d.owner[sem_idx[p]] = '0;
                    rel_mask[sem_idx[p]]   = 1'b1;
                end else begin
                    rsp_deny[p] = 1'b1;
                end
                rsp_owner[p] = st_d.owner[sem_idx[p]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Which semaphores saw a lock read this cycle (for checking only).
    logic [NSEM-1:0] rd_hit;
    always_comb begin
        rd_hit = '0;
        for (int p = 0; p < NPROC; p++) begin
            if (rd_req[p]) rd_hit[sem_idx[p]] = 1'b1;
        end
    end

    for (genvar i = 0; i < NSEM; i++) begin : g_chk
        assert_no_direct_handover_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st_q.owner[i]) != '0 && st_q.owner[i] != '0 &&
             st_q.owner[i] != $past(st_q.owner[i])) |-> $past(rel_mask[i]));
        assert_lock_only_by_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st_q.owner[i]) == '0 && st_q.owner[i] != '0) |-> $past(rd_hit[i]));
    end
endmodule

// File: rtl/hsem_irq_bank.sv
module hsem_irq_bank #(
    parameter int NSEM = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ier_we,
    input  logic            icr_we,
    input  logic [NSEM-1:0] wbits,
    input  logic [NSEM-1:0] rel_mask,
    output logic [NSEM-1:0] ier_q,
    output logic [NSEM-1:0] ris_q,
    output logic [NSEM-1:0] mis,
    output logic            irq
);
    typedef struct packed {
        logic [NSEM-1:0] ier;
        logic [NSEM-1:0] ris;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NSEM-1:0] set_v, clr_v;

    always_comb begin
        st_d  = st_q;
        set_v = rel_mask & st_q.ier;
        clr_v = icr_we ? wbits : '0;
        if (ier_we) st_d.ier = wbits;
        st_d.ris = (st_q.ris & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ier_q = st_q.ier;
    assign ris_q = st_q.ris;
    assign mis   = st_q.ris & st_q.ier;
    assign irq   = |mis;

    assert_enabled_release_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rel_mask & ier_q) != '0) |=> ((ris_q & $past(rel_mask & ier_q)) == $past(rel_mask & ier_q)));
    assert_raw_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ris_q & ~$past(ris_q) & ~$past(rel_mask & ier_q)) == '0));
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        icr_we |=> ((ris_q & $past(wbits & ~(rel_mask & ier_q))) == '0));
endmodule

// File: rtl/hsem_top.sv
module hsem_top #(
    parameter int NSEM  = 16,
    parameter int NPROC = 3,
    parameter int DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPROC-1:0]      p_req,
    input  logic [NPROC-1:0]      p_we,
    input  logic [NPROC*5-1:0]    p_addr,
    input  logic [NPROC*DW-1:0]   p_wdata,
    output logic [NPROC*DW-1:0]   p_rdata,
    output logic [NPROC-1:0]      irq
);
    import hsem_pkg::*;

    localparam int IDW = $clog2(NPROC + 1);
    localparam int SIW = $clog2(NSEM);
    localparam int AW  = SIW + 1;

    typedef struct packed {
        logic [NPROC-1:0][DW-1:0] rsp;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NPROC-1:0][AW-1:0]   addr_v;
    logic [NPROC-1:0][DW-1:0]   wdata_v;
    logic [NPROC-1:0]           sem_rd, sem_wr, irq_rd, ier_we, icr_we;
    logic [NPROC-1:0][SIW-1:0]  sem_idx;
    logic [NPROC-1:0][IDW-1:0]  rel_id;
    logic [NPROC-1:0][1:0]      reg_sel;
    logic [NPROC-1:0][IDW-1:0]  rsp_owner;
    logic [NPROC-1:0]           rsp_deny;
    logic [NSEM-1:0]            rel_mask;
    logic [NPROC-1:0][NSEM-1:0] ier_v, ris_v, mis_v, wbits_v;

    assign addr_v  = p_addr;
    assign wdata_v = p_wdata;

    always_comb begin
        for (int p = 0; p < NPROC; p++) begin
            logic in_sem, in_irq;
            in_sem     = !addr_v[p][AW-1];
            in_irq     = addr_v[p][AW-1] && (addr_v[p][SIW-1:2] == '0);
            sem_rd[p]  = p_req[p] && !p_we[p] && in_sem;
            sem_wr[p]  = p_req[p] &&  p_we[p] && in_sem;
            irq_rd[p]  = p_req[p] && !p_we[p] && in_irq;
            sem_idx[p] = addr_v[p][SIW-1:0];
            reg_sel[p] = addr_v[p][1:0];
            ier_we[p]  = p_req[p] && p_we[p] && in_irq && (reg_sel[p] == IRQ_ENABLE);
            icr_we[p]  = p_req[p] && p_we[p] && in_irq && (reg_sel[p] == IRQ_CLEAR);
            wbits_v[p] = wdata_v[p][NSEM-1:0];
            // A release word with stray upper bits carries ID 0, which never matches.
            rel_id[p]  = (wdata_v[p][DW-1:IDW] == '0) ? wdata_v[p][IDW-1:0] : '0;
        end
    end

    hsem_lock_core #(
        .NSEM (NSEM),
        .NPROC(NPROC),
        .IDW  (IDW),
        .SIW  (SIW)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (sem_rd),
        .wr_req   (sem_wr),
        .sem_idx  (sem_idx),
        .rel_id   (rel_id),
        .rsp_owner(rsp_owner),
        .rsp_deny (rsp_deny),
        .rel_mask (rel_mask)
    );

    for (genvar p = 0; p < NPROC; p++) begin : g_bank
        hsem_irq_bank #(.NSEM(NSEM)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ier_we  (ier_we[p]),
            .icr_we  (icr_we[p]),
            .wbits   (wbits_v[p]),
            .rel_mask(rel_mask),
            .ier_q   (ier_v[p]),
            .ris_q   (ris_v[p]),
            .mis     (mis_v[p]),
            .irq     (irq[p])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NPROC; p++) begin
            if (p_req[p]) begin
                st_d.rsp[p] = '0;
                if (sem_rd[p] || sem_wr[p]) begin
                    st_d.rsp[p][RSP_LOCKED_BIT] = rsp_owner[p] != '0;
                    st_d.rsp[p][RSP_DENIED_BIT] = rsp_deny[p];
                    st_d.rsp[p][IDW-1:0]        = rsp_owner[p];
                end else if (irq_rd[p]) begin
                    case (reg_sel[p])
                        IRQ_ENABLE: st_d.rsp[p][NSEM-1:0] = ier_v[p];
                        IRQ_RAW:    st_d.rsp[p][NSEM-1:0] = ris_v[p];
                        IRQ_MASKED: st_d.rsp[p][NSEM-1:0] = mis_v[p];
                        default:    st_d.rsp[p]           = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p_rdata = st_q.rsp;

    for (genvar p = 0; p < NPROC; p++) begin : g_chk
        assert_read_reports_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sem_rd[p] |=> st_q.rsp[p][RSP_LOCKED_BIT]);
        assert_granted_read_names_reader_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (sem_rd[p] && !rsp_deny[p]) |=> (st_q.rsp[p][IDW-1:0] == IDW'(p + 1)));
    end
endmodule

// File: tb/tb_hsem_top.sv
`timescale 1ns/1ps
module tb_hsem_top;
    localparam int NP = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic [NP-1:0]       req, we;
    logic [NP-1:0][4:0]  addr;
    logic [NP-1:0][31:0] wd;
    logic [NP-1:0][31:0] rd;
    logic [NP-1:0]       irq;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [15:0] m_ier [NP];
    logic [15:0] m_ris [NP];

    always #2.5 clk = ~clk;

    hsem_top dut (
        .clk(clk), .rst_n(rst_n), .p_req(req), .p_we(we),
        .p_addr(addr), .p_wdata(wd), .p_rdata(rd), .irq(irq)
    );

    function automatic logic [31:0] sw(bit l, bit d, int id);
        return {l, d, 28'b0, 2'(id)};
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic op1(input int p, input bit w, input logic [4:0] a, input logic [31:0] d);
        req = '0; we = '0;
        req[p] = 1'b1; we[p] = w; addr[p] = a; wd[p] = d;
        @(negedge clk);
        req = '0;
    endtask

    task automatic rel(input int s);
        for (int b = 0; b < NP; b++) m_ris[b][s] = m_ris[b][s] | m_ier[b][s];
    endtask

    task automatic check_banks(input string tag);
        for (int b = 0; b < NP; b++) begin
            op1(b, 0, 5'h11, 0);
            chk({"R8 raw ", tag}, rd[b], {16'h0, m_ris[b]});
            op1(b, 0, 5'h12, 0);
            chk({"R9 masked ", tag}, rd[b], {16'h0, m_ris[b] & m_ier[b]});
            chk({"R11 irq ", tag}, 32'(irq[b]), 32'(|(m_ris[b] & m_ier[b])));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++; nvec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; we = '0; addr = '0; wd = '0;
        for (int b = 0; b < NP; b++) begin m_ier[b] = '0; m_ris[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 32'(irq), 0);
        for (int b = 0; b < NP; b++) chk("R1 rsp", rd[b], 0);
        for (int b = 0; b < NP; b++) begin
            op1(b, 0, 5'h10, 0); chk("R1 enable", rd[b], 0);
            op1(b, 0, 5'h11, 0); chk("R1 raw", rd[b], 0);
            op1(b, 0, 5'h12, 0); chk("R1 masked", rd[b], 0);
        end

        // R7: enable masks, upper bits ignored
        m_ier[0] = 16'hFFFF; m_ier[1] = 16'hA5A5; m_ier[2] = 16'h0F0F;
        for (int b = 0; b < NP; b++) begin
            op1(b, 1, 5'h10, {16'hDEAD, m_ier[b]});
            op1(b, 0, 5'h10, 0);
            chk("R7 enable readback", rd[b], {16'h0, m_ier[b]});
        end

        // Sweep every semaphore
        for (int s = 0; s < 16; s++) begin
            int o, n;
            o = s % 3;
            n = (o + 1) % 3;
            op1(o, 0, 5'(s), 0);
            chk("R2 lock", rd[o], sw(1, 0, o + 1));
            for (int q = 0; q < NP; q++) begin
                if (q != o) begin
                    op1(q, 0, 5'(s), 0);
                    chk("R3 held", rd[q], sw(1, 1, o + 1));
                    op1(q, 1, 5'(s), 32'(q + 1));
                    chk("R5 wrong id", rd[q], sw(1, 1, o + 1));
                end
            end
            op1(o, 1, 5'(s), 0);
            chk("R5 id zero", rd[o], sw(1, 1, o + 1));
            op1(o, 1, 5'(s), 32'h100 | 32'(o + 1));
            chk("R5 stray bits", rd[o], sw(1, 1, o + 1));
            op1(o, 1, 5'(s), 32'(o + 1));
            chk("R4 release", rd[o], 0);
            rel(s);
            op1(o, 1, 5'(s), 32'(o + 1));
            chk("R5 free", rd[o], sw(0, 1, 0));
            op1(n, 0, 5'(s), 0);
            chk("R4 reacquire", rd[n], sw(1, 0, n + 1));
            op1(n, 1, 5'(s), 32'(n + 1));
            chk("R4 release again", rd[n], 0);
            rel(s);
            if (s % 4 == 3) check_banks("sweep");
        end

        // R10: write-one-to-clear
        begin
            logic [15:0] masks [NP];
            masks[0] = 16'h00F0; masks[1] = 16'hFF00; masks[2] = 16'h0003;
            for (int b = 0; b < NP; b++) begin
                op1(b, 1, 5'h13, {16'hFFFF, masks[b]});
                m_ris[b] = m_ris[b] & ~masks[b];
                op1(b, 0, 5'h13, 0);
                chk("R10 clear reads zero", rd[b], 0);
            end
            check_banks("after clear");
        end

        // R10: release wins over same-cycle clear
        op1(0, 0, 5'h0, 0);
        chk("R2 lock s0", rd[0], sw(1, 0, 1));
        req = 3'b011; we = 3'b011;
        addr[0] = 5'h00; wd[0] = 32'd1;
        addr[1] = 5'h13; wd[1] = 32'h0001;
        @(negedge clk);
        req = '0;
        chk("R4 release with clear", rd[0], 0);
        m_ris[1] = m_ris[1] & ~16'h0001;
        rel(0);
        op1(1, 0, 5'h11, 0);
        chk("R10 set wins", rd[1], {16'h0, m_ris[1]});

        // R6: contention, every pair
        for (int a = 0; a < NP; a++) begin
            for (int b = a + 1; b < NP; b++) begin
                req = '0; we = '0;
                req[a] = 1'b1; req[b] = 1'b1;
                addr[a] = 5'd7; addr[b] = 5'd7;
                @(negedge clk);
                req = '0;
                chk("R6 pair winner", rd[a], sw(1, 0, a + 1));
                chk("R6 pair loser", rd[b], sw(1, 1, a + 1));
                op1(a, 1, 5'd7, 32'(a + 1));
                chk("R6 pair cleanup", rd[a], 0);
                rel(7);
            end
        end
        req = 3'b111; we = '0;
        addr[0] = 5'd9; addr[1] = 5'd9; addr[2] = 5'd9;
        @(negedge clk);
        req = '0;
        chk("R6 triple p0", rd[0], sw(1, 0, 1));
        chk("R6 triple p1", rd[1], sw(1, 1, 1));
        chk("R6 triple p2", rd[2], sw(1, 1, 1));
        // release by p0 and read by p1 in one cycle
        req = 3'b011; we = 3'b001;
        addr[0] = 5'd9; wd[0] = 32'd1;
        addr[1] = 5'd9;
        @(negedge clk);
        req = '0;
        rel(9);
        chk("R6 ordered release", rd[0], 0);
        chk("R6 ordered acquire", rd[1], sw(1, 0, 2));
        op1(1, 1, 5'd9, 32'd2);
        chk("R4 release p1", rd[1], 0);
        rel(9);
        check_banks("contention");

        // R12: read-only and reserved offsets
        op1(0, 1, 5'h11, 32'h0000FFFF);
        op1(0, 1, 5'h12, 32'h0000FFFF);
        op1(0, 1, 5'h1A, 32'h0000FFFF);
        op1(0, 0, 5'h1A, 0);
        chk("R12 reserved read", rd[0], 0);
        op1(0, 0, 5'h10, 0);
        chk("R12 enable untouched", rd[0], {16'h0, m_ier[0]});
        check_banks("R12 ignored writes");
        for (int b = 0; b < NP; b++) begin
            op1(b, 1, 5'h13, 32'hFFFF);
            m_ris[b] = '0;
        end
        check_banks("all cleared");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule